// File: doc/BRIEF.md
# Transmit Status Word Generator

This block sits beside the transmit engine of a 10/100 Ethernet MAC. For each packet it tracks what happened while the packet was being sent. It counts the collision pulses reported for the attempt. It notes whether the medium ever forced the transmitter to hold off. It also measures the total time, in bit-time ticks, that the transmitter spent held off.

When the packet finishes, the block emits a packed status word and a one-cycle valid strobe. If the deferral check is enabled and the accumulated hold-off exceeds a fixed limit of bit times, the block ends the packet on its own. In that case it raises an abort strobe and reports the status word with the excessive-deferral flag set. The transmit engine is expected to drop the packet when it sees the abort.

A packet opens with a start strobe and closes with an end strobe. Every counter and flag is cleared at each start, so nothing carries over from one packet to the next.

Top module: `txs_status_gen`

## Requirements
- R1: The status word is 16 bits with this layout: bit 0 = deferred, bit 2 = excessive deferral, bits 6:3 = collision count, bit 8 = excessive collision. Bits 1, 7 and 15:9 always read as zero.
- R2: Each cycle in which `coll_pulse` is high while a packet is open adds one to the collision count. The count saturates at 15.
- R3: A `tx_start` clears the collision count, the deferral timer and every flag. This also applies when a packet is already open, so the next status word reflects only the new packet.
- R4: The deferred bit is set if `defer_act` was high in any cycle while the packet was open. Ticks are not needed for this bit.
- R5: The deferral timer advances only in cycles where `bit_tick` and `defer_act` are both high while the packet is open. Ticks that arrive while `defer_act` is low are not counted.
- R6: With `defer_chk_en` high, the packet is aborted once the timer holds more than DEFER_LIMIT counted ticks. The abort takes effect one cycle after the tick that pushes the count past the limit. In that cycle `stat_valid` and `tx_abort` both pulse, and bit 2 of the word is set. A count of exactly DEFER_LIMIT does not abort.
- R7: With `defer_chk_en` low, no amount of deferral aborts the packet, and bit 2 stays zero.
- R8: The excessive-collision bit is set if `excess_coll` was high during the open packet, including the cycle of `tx_end`.
- R9: `stat_valid` pulses for exactly one cycle, in the cycle after `tx_end` is seen on an open packet. `stat_word` holds its value until the next report.
- R10: A `tx_end` while no packet is open is ignored and produces no report. This includes a `tx_end` after an abort has already closed the packet.
- R11: While reset is low, and after it is released, `stat_valid`, `tx_abort` and `stat_word` are zero until the first report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| defer_act | input | 1 | High while the transmitter must hold off (carrier sensed or deferring) |
| coll_pulse | input | 1 | One-cycle pulse per collision seen |
| excess_coll | input | 1 | Attempt limit reached for this packet |
| defer_chk_en | input | 1 | Control bit enabling the excessive-deferral abort |
| tx_start | input | 1 | Opens a packet and clears all per-packet state |
| tx_end | input | 1 | Closes the open packet |
| stat_word | output | 16 | Packed status of the last reported packet |
| stat_valid | output | 1 | One-cycle strobe marking a new status word |
| tx_abort | output | 1 | One-cycle strobe when deferral exceeded the limit |

## Verification
The bench builds the block with DEFER_LIMIT set to 20 rather than 24288. This lets both sides of the deferral boundary be driven within a few dozen cycles: exactly 20 counted ticks, and one more. The exact cycle of the abort strobe can then be checked. The short limit also makes it cheap to show that uncounted ticks (no deferral) and hold-off without ticks never reach the limit. It also exercises the disabled-check path well past the limit.

// File: rtl/txs_pkg.sv
// Package: shared field positions and the per-packet flag bundle for the
// transmit status word generator. Assumes a 16-bit status word.
package txs_pkg;
    localparam int unsigned STAT_W    = 16;
    localparam int unsigned CC_W      = 4;   // collision count width
    localparam int unsigned BIT_DEF   = 0;   // deferred
    localparam int unsigned BIT_EXDEF = 2;   // excessive deferral
    localparam int unsigned CC_LO     = 3;   // collision count low bit
    localparam int unsigned BIT_EXCOL = 8;   // excessive collision

    typedef struct packed {
        logic            deferred;
        logic            ex_defer;
        logic [CC_W-1:0] coll;
        logic            ex_coll;
    } txs_flags_t;
endpackage

// File: rtl/txs_coll_ctr.sv
// Saturating collision counter. Clears on clr (priority over inc), adds one
// per inc cycle, and stops at all ones. Assumes inc is already qualified
// by the caller with "packet open".
module txs_coll_ctr #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = '1;

    // Count register: reset/clear to zero, saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (inc && cnt != CMAX)  cnt <= cnt + 1'b1;
    end

    assert_coll_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt == CMAX) |=> (cnt == CMAX));
    assert_coll_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/txs_defer_timer.sv
// Deferral timer in bit times. Advances on run (tick while deferring inside
// an open packet), clears on clr, saturates one above LIMIT so "over" stays
// asserted once the limit has been exceeded.
module txs_defer_timer #(
    parameter int unsigned LIMIT = 24288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic over
);
    localparam int unsigned TW = $clog2(LIMIT + 2);
    localparam logic [TW-1:0] LIM_V = TW'(LIMIT);
    localparam logic [TW-1:0] TOP_V = TW'(LIMIT + 1);

    logic [TW-1:0] cnt;

    // Timer register: clear per packet, count qualified ticks up to TOP_V.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (run && cnt != TOP_V) cnt <= cnt + 1'b1;
    end

    // Limit compare: strictly more than LIMIT ticks.
    always_comb over = (cnt > LIM_V);

    assert_timer_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !run) |=> $stable(cnt));
    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_V);
endmodule

// File: rtl/txs_status_pack.sv
// Status packer: places the per-packet flags at their fixed bit positions
// and forces every other bit to zero. Purely combinational.
module txs_status_pack
    import txs_pkg::*;
(
    input  txs_flags_t        flags,
    output logic [STAT_W-1:0] word
);
    // Field placement; unused bits default to zero.
    always_comb begin
        word                  = '0;
        word[BIT_DEF]         = flags.deferred;
        word[BIT_EXDEF]       = flags.ex_defer;
        word[CC_LO +: CC_W]   = flags.coll;
        word[BIT_EXCOL]       = flags.ex_coll;
    end
endmodule

// File: rtl/txs_status_gen.sv
// Transmit status word generator (top). Opens a packet on tx_start, tracks
// collisions, deferral and excessive collision, aborts on over-long deferral
// when enabled, and reports a packed word with a one-cycle valid strobe.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module txs_status_gen
    import txs_pkg::*;
#(
    parameter int unsigned DEFER_LIMIT = 24288
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              defer_act,
    input  logic              coll_pulse,
    input  logic              excess_coll,
    input  logic              defer_chk_en,
    input  logic              tx_start,
    input  logic              tx_end,
    output logic [STAT_W-1:0] stat_word,
    output logic              stat_valid,
    output logic              tx_abort
);
    logic            active_q;
    logic            deferred_q;
    logic            excoll_q;
    logic [CC_W-1:0] coll_cnt;
    logic            over;
    logic            end_ev;
    logic            abort_ev;
    logic            done;
    txs_flags_t      flags;
    logic [STAT_W-1:0] packed_word;

    // Event decode: legal end, deferral abort, and their union.
    always_comb begin
        end_ev   = tx_end && active_q;
        abort_ev = active_q && defer_chk_en && over;
        done     = end_ev || abort_ev;
    end

    txs_coll_ctr #(.CW(CC_W)) u_coll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_start),
        .inc   (active_q && coll_pulse),
        .cnt   (coll_cnt)
    );

    txs_defer_timer #(.LIMIT(DEFER_LIMIT)) u_defer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_start),
        .run   (active_q && defer_act && bit_tick),
        .over  (over)
    );

    // Packet-open flag: set by start, cleared by end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_q <= 1'b0;
        else if (tx_start) active_q <= 1'b1;
        else if (done)     active_q <= 1'b0;
    end

    // Sticky per-packet flags for deferral and excessive collision.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_start) begin
            deferred_q <= 1'b0;
            excoll_q   <= 1'b0;
        end else if (active_q) begin
            if (defer_act)   deferred_q <= 1'b1;
            if (excess_coll) excoll_q   <= 1'b1;
        end
    end

    // Flag bundle at report time; excessive collision includes this cycle.
    always_comb begin
        flags.deferred = deferred_q;
        flags.ex_defer = abort_ev;
        flags.coll     = coll_cnt;
        flags.ex_coll  = excoll_q || excess_coll;
    end

    txs_status_pack u_pack (
        .flags (flags),
        .word  (packed_word)
    );

    // Output registers: strobe per report, word held between reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            tx_abort   <= 1'b0;
            stat_word  <= '0;
        end else begin
            stat_valid <= done;
            tx_abort   <= abort_ev;
            if (done) stat_word <= packed_word;
        end
    end

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_word[1] == 1'b0 && stat_word[7] == 1'b0 &&
                        stat_word[STAT_W-1:9] == '0));
    assert_abort_reports_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (stat_valid && stat_word[BIT_EXDEF] && stat_word[BIT_DEF]));
    assert_abort_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> $past(defer_chk_en));
    assert_valid_after_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(active_q));
    assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |=> (stat_valid || $stable(stat_word)));
    assert_no_idle_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !tx_start) |=> !stat_valid);
endmodule

// File: tb/txs_status_gen_bench.sv
`timescale 1ns/1ps
module txs_status_gen_bench;
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, defer_act = 0, coll_pulse = 0, excess_coll = 0;
    logic defer_chk_en = 1, tx_start = 0, tx_end = 0;
    logic [15:0] stat_word;
    logic stat_valid, tx_abort;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    txs_status_gen #(.DEFER_LIMIT(LIM)) u_txs_status_gen (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .defer_act(defer_act),
        .coll_pulse(coll_pulse), .excess_coll(excess_coll),
        .defer_chk_en(defer_chk_en), .tx_start(tx_start), .tx_end(tx_end),
        .stat_word(stat_word), .stat_valid(stat_valid), .tx_abort(tx_abort)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic start_pkt();
        tx_start = 1; step(); tx_start = 0;
    endtask

    task automatic collide(int n);
        for (int i = 0; i < n; i++) begin
            coll_pulse = 1; step(); coll_pulse = 0;
        end
    endtask

    // End the packet and check the report (R9 timing, R1 reserved bits).
    task automatic end_and_check(string req, int exp_word);
        tx_end = 1; step(); tx_end = 0; excess_coll = 0;
        chk("R9", "valid after end", stat_valid, 1);
        chk(req, "status word", stat_word, exp_word);
        chk("R1", "reserved bits", stat_word & 16'hFE82, 0);
        step();
        chk("R9", "valid one cycle", stat_valid, 0);
        chk("R9", "word held", stat_word, exp_word);
    endtask

    // Drive deferral cycles; return the cycle index (1-based) a report was seen, 0 if none.
    task automatic defer_run(int n, bit ticks, output int seen_at, output int word);
        seen_at = 0; word = 0;
        defer_act = 1; bit_tick = ticks;
        for (int i = 1; i <= n; i++) begin
            step();
            if (stat_valid && seen_at == 0) begin
                seen_at = i; word = stat_word;
                chk("R6", "abort strobe with valid", tx_abort, 1);
            end
        end
        defer_act = 0; bit_tick = 0;
    endtask

    task automatic t_reset();
        chk("R11", "valid in reset", stat_valid, 0);
        chk("R11", "abort in reset", tx_abort, 0);
        chk("R11", "word in reset", stat_word, 0);
        rst_n = 1; step(); step();
        chk("R11", "valid after reset", stat_valid, 0);
    endtask

    task automatic t_plain();
        start_pkt(); step(); step();
        end_and_check("R1", 16'h0000);
    endtask

    task automatic t_coll();
        start_pkt(); collide(3); step();
        end_and_check("R2", 16'h0018);
        start_pkt(); collide(18);
        end_and_check("R2", 16'h0078);
    endtask

    task automatic t_restart();
        int s, w;
        start_pkt(); collide(5); excess_coll = 1; step(); excess_coll = 0;
        defer_run(4, 1, s, w);
        start_pkt(); collide(1);
        end_and_check("R3", 16'h0008);
    endtask

    task automatic t_excoll();
        start_pkt(); collide(2);
        excess_coll = 1;
        end_and_check("R8", 16'h0110);
        start_pkt(); excess_coll = 1; step(); excess_coll = 0; step();
        end_and_check("R8", 16'h0100);
    endtask

    task automatic t_defer_no_tick();
        int s, w;
        start_pkt(); defer_run(3 * LIM, 0, s, w);
        chk("R4", "no abort without ticks", s, 0);
        end_and_check("R4", 16'h0001);
    endtask

    task automatic t_tick_no_defer();
        int s, w;
        start_pkt();
        bit_tick = 1; for (int i = 0; i < 3 * LIM; i++) step(); bit_tick = 0;
        defer_run(LIM, 1, s, w);
        chk("R5", "free ticks not counted", s, 0);
        end_and_check("R5", 16'h0001);
    endtask

    task automatic t_exact_limit();
        int s, w;
        start_pkt(); defer_run(LIM, 1, s, w);
        step(); step(); step();
        chk("R6", "exact limit no abort", s == 0 && !stat_valid, 1);
        end_and_check("R6", 16'h0001);
    endtask

    task automatic t_abort();
        int s, w;
        start_pkt(); collide(2); defer_run(LIM + 4, 1, s, w);
        chk("R6", "abort cycle", s, LIM + 2);
        chk("R6", "abort word", w, 16'h0015);
        tx_end = 1; step(); tx_end = 0;
        chk("R10", "end after abort ignored", stat_valid, 0);
        chk("R6", "abort one cycle", tx_abort, 0);
    endtask

    task automatic t_abort_disabled();
        int s, w;
        defer_chk_en = 0;
        start_pkt(); defer_run(LIM + 10, 1, s, w);
        chk("R7", "no abort when disabled", s, 0);
        end_and_check("R7", 16'h0001);
        defer_chk_en = 1;
    endtask

    task automatic t_idle_end();
        tx_end = 1; step(); tx_end = 0;
        chk("R10", "idle end ignored", stat_valid, 0);
        step();
        chk("R10", "idle end no later report", stat_valid, 0);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        t_reset();
        t_plain();
        t_coll();
        t_restart();
        t_excoll();
        t_defer_no_tick();
        t_tick_no_defer();
        t_exact_limit();
        t_abort();
        t_abort_disabled();
        t_idle_end();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule